// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a parameterised ring of boundary cells that sits between the core logic and the package pins. It has input-pin cells, output-pin cells and a single shared output-enable control cell. Each cell holds a capture/shift flip-flop, clocked on the rising test clock, and an update latch, loaded on the falling test clock. A test access port controller, which is not part of this block, supplies three data-register strobes (capture, shift, update) and a decoded 3-bit instruction mode. From these the block sets how each pin and each core input is driven.

Serial data enters at `tdi` and leaves at `scan_out`. That path runs either through the whole chain or through a one-bit bypass stage, depending on the mode. In the functional mode and in SAMPLE the pins and core see each other directly, with no state in the path. The test instructions steer pins, core inputs or the shared output enable from the update latches, or force the outputs into high impedance.

Top module: `bscan_chain`

## Requirements
- R1: After asynchronous reset (`trst_n` low), every chain flip-flop, every update latch and the bypass flip-flop hold 0. In SAMPLE mode an immediate shift of the whole chain therefore returns all zeros, and in EXTEST mode `pin_out` and `pin_oe` are 0.
- R2: In mode 0 (functional), in mode 1 (SAMPLE/PRELOAD) and in the unused codes 6 and 7, the paths are straight wires: `pin_out` = `core_out`, `pin_oe` = `core_oe` and `core_in` = `pin_in`.
- R3: When the chain is selected (modes 1, 2, 3), a rising test clock with `cap_dr` high loads cell bit i from `pin_in[i]` for i < N_IN, loads bit N_IN+j from `core_out[j]`, and loads the top bit from `core_oe`. Capture takes priority over shift. Under SAMPLE this leaves the functional paths unchanged.
- R4: When the chain is selected, `scan_out` shows chain bit 0. Each rising clock with `shift_dr` high moves bit k+1 into bit k and loads `tdi` into the top bit. After N_IN+N_OUT+1 shifts, the first bit shifted in sits in bit 0.
- R5: With the chain selected, a falling test clock with `upd_dr` high copies every chain bit into its update latch (PRELOAD). At no other time does any update latch change, so the pins hold steady while data is captured or shifted.
- R6: In mode 2 (EXTEST), `pin_out[j]` is driven from output latch j, `pin_oe` is driven from the control latch, and `core_in` follows `pin_in`.
- R7: In mode 3 (INTEST), `core_in[i]` is driven from input latch i, and the pins are driven from the latches as in R6. A capture records `core_out` as the response.
- R8: In mode 4 (CLAMP), the pins and `pin_oe` are driven from the latches and `core_in` follows `pin_in`. The serial path runs through the bypass flip-flop: capture loads 0 and shift loads `tdi`, giving a one-cycle delay.
- R9: In mode 5 (HIGHZ), `pin_oe` is 0 whatever the value of `core_oe`, `pin_out` follows `core_out`, and the serial path runs through the bypass flip-flop.
- R10: In modes 0, 4, 5, 6 and 7, the strobes leave both the chain flip-flops and the update latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| mode | input | 3 | Decoded instruction: 0 functional, 1 sample/preload, 2 extest, 3 intest, 4 clamp, 5 highz |
| cap_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| upd_dr | input | 1 | Update strobe |
| tdi | input | 1 | Serial test data in |
| scan_out | output | 1 | Serial test data out |
| pin_in | input | N_IN | Values arriving from the input pins |
| core_in | output | N_IN | Values delivered to the core inputs |
| core_out | input | N_OUT | Values produced by the core outputs |
| pin_out | output | N_OUT | Values driven onto the output pins |
| core_oe | input | 1 | Output enable from the core |
| pin_oe | output | 1 | Shared output enable to the pads (0 = high impedance) |

## Verification
The hardest case to reach from the ports is showing that the unselected instructions leave the chain untouched. In CLAMP and HIGHZ the chain's contents cannot be seen at `scan_out`. The stimulus therefore leaves a known pattern in the chain while in INTEST, then drives captures, shifts and updates through the bypass modes. It then returns to SAMPLE without a capture and shifts the chain out, expecting the same pattern. It also checks that the clamped pins did not move.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam logic [2:0] BS_FUNC   = 3'd0;
  localparam logic [2:0] BS_SAMPLE = 3'd1;
  localparam logic [2:0] BS_EXTEST = 3'd2;
  localparam logic [2:0] BS_INTEST = 3'd3;
  localparam logic [2:0] BS_CLAMP  = 3'd4;
  localparam logic [2:0] BS_HIGHZ  = 3'd5;

  // chain sits between tdi and scan_out
  function automatic logic chain_on(input logic [2:0] m);
    return (m == BS_SAMPLE) || (m == BS_EXTEST) || (m == BS_INTEST);
  endfunction

  // output pins and shared enable come from the update latches
  function automatic logic pins_from_latch(input logic [2:0] m);
    return (m == BS_EXTEST) || (m == BS_INTEST) || (m == BS_CLAMP);
  endfunction

  // core inputs come from the update latches
  function automatic logic core_from_latch(input logic [2:0] m);
    return m == BS_INTEST;
  endfunction

  // all outputs forced to high impedance
  function automatic logic outputs_off(input logic [2:0] m);
    return m == BS_HIGHZ;
  endfunction

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic en,
  input  logic cap,
  input  logic shf,
  input  logic upd,
  input  logic par_in,
  input  logic ser_in,
  output logic ser_q,
  output logic upd_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ser_q <= 1'b0;
    else if (en && cap)   ser_q <= par_in;
    else if (en && shf)   ser_q <= ser_in;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)          upd_q <= 1'b0;
    else if (en && upd)   upd_q <= ser_q;
  end

endmodule

// File: rtl/bscan_bypass.sv
module bscan_bypass (
  input  logic tck,
  input  logic trst_n,
  input  logic en,
  input  logic cap,
  input  logic shf,
  input  logic tdi,
  output logic q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          q <= 1'b0;
    else if (en && cap)   q <= 1'b0;
    else if (en && shf)   q <= tdi;
  end

endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic [2:0]       mode,
  input  logic [N_IN-1:0]  pin_in,
  input  logic [N_IN-1:0]  lat_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] lat_out,
  input  logic             core_oe,
  input  logic             lat_oe,
  output logic [N_IN-1:0]  core_in,
  output logic [N_OUT-1:0] pin_out,
  output logic             pin_oe
);
  import bscan_pkg::*;

  logic use_pin_lat, use_core_lat, force_off;

  always_comb begin
    use_pin_lat  = pins_from_latch(mode);
    use_core_lat = core_from_latch(mode);
    force_off    = outputs_off(mode);
    core_in      = use_core_lat ? lat_in  : pin_in;
    pin_out      = use_pin_lat  ? lat_out : core_out;
    if (force_off)        pin_oe = 1'b0;
    else if (use_pin_lat) pin_oe = lat_oe;
    else                  pin_oe = core_oe;
  end

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic [2:0]       mode,
  input  logic             cap_dr,
  input  logic             shift_dr,
  input  logic             upd_dr,
  input  logic             tdi,
  output logic             scan_out,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] pin_out,
  input  logic             core_oe,
  output logic             pin_oe
);
  import bscan_pkg::*;

  localparam int L      = N_IN + N_OUT + 1;
  localparam int OUT_LO = N_IN;
  localparam int CTL    = L - 1;

  logic         chain_sel;
  logic [L-1:0] par_vec;
  logic [L-1:0] chain_q;
  logic [L-1:0] upd_q;
  logic         byp_q;

  assign chain_sel = chain_on(mode);
  assign par_vec   = {core_oe, core_out, pin_in};

  for (genvar i = 0; i < L; i++) begin : g_cell
    logic nxt;
    if (i == L - 1) begin : g_head
      assign nxt = tdi;
    end else begin : g_link
      assign nxt = chain_q[i+1];
    end
    bscan_cell u_cell (
      .tck    (tck),
      .trst_n (trst_n),
      .en     (chain_sel),
      .cap    (cap_dr),
      .shf    (shift_dr),
      .upd    (upd_dr),
      .par_in (par_vec[i]),
      .ser_in (nxt),
      .ser_q  (chain_q[i]),
      .upd_q  (upd_q[i])
    );
  end

  bscan_bypass u_byp (
    .tck    (tck),
    .trst_n (trst_n),
    .en     (!chain_sel),
    .cap    (cap_dr),
    .shf    (shift_dr),
    .tdi    (tdi),
    .q      (byp_q)
  );

  bscan_pinmux #(.N_IN(N_IN), .N_OUT(N_OUT)) u_mux (
    .mode     (mode),
    .pin_in   (pin_in),
    .lat_in   (upd_q[N_IN-1:0]),
    .core_out (core_out),
    .lat_out  (upd_q[CTL-1:OUT_LO]),
    .core_oe  (core_oe),
    .lat_oe   (upd_q[CTL]),
    .core_in  (core_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  assign scan_out = chain_sel ? chain_q[0] : byp_q;

endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                      tck,
  input logic                      trst_n,
  input logic [2:0]                mode,
  input logic                      cap_dr,
  input logic                      shift_dr,
  input logic                      upd_dr,
  input logic                      tdi,
  input logic                      scan_out,
  input logic                      pin_oe,
  input logic [N_IN-1:0]           core_in,
  input logic                      chain_sel,
  input logic [N_IN+N_OUT:0]       chain_q,
  input logic [N_IN+N_OUT:0]       upd_q
);
  localparam int L = N_IN + N_OUT + 1;

  a_r9_highz_off: assert property (@(posedge tck) disable iff (!trst_n)
    mode == 3'd5 |-> !pin_oe);

  a_r7_intest_core: assert property (@(posedge tck) disable iff (!trst_n)
    mode == 3'd3 |-> core_in == upd_q[N_IN-1:0]);

  a_r6_extest_oe: assert property (@(posedge tck) disable iff (!trst_n)
    mode == 3'd2 |-> pin_oe == upd_q[L-1]);

  a_r5_latch_hold: assert property (@(posedge tck) disable iff (!trst_n)
    !(upd_dr && chain_sel) |-> $stable(upd_q));

  a_r4_shift_step: assert property (@(posedge tck) disable iff (!trst_n)
    (chain_sel && shift_dr && !cap_dr) |=>
      chain_q == {$past(tdi), $past(chain_q[L-1:1])});

  a_r8_bypass_delay: assert property (@(posedge tck) disable iff (!trst_n)
    (!chain_sel && shift_dr && !cap_dr) |=> (chain_sel || scan_out == $past(tdi)));

  a_r10_idle_chain: assert property (@(posedge tck) disable iff (!trst_n)
    !chain_sel |=> $stable(chain_q));

endmodule

bind bscan_chain bscan_chain_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/test_bscan_chain.sv
`timescale 1ns/1ps
module test_bscan_chain;
  localparam int N_IN  = 4;
  localparam int N_OUT = 4;
  localparam int L     = N_IN + N_OUT + 1;

  logic             tck = 1'b0;
  logic             trst_n = 1'b0;
  logic [2:0]       mode = 3'd0;
  logic             cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
  logic             scan_out;
  logic [N_IN-1:0]  pin_in = '0;
  logic [N_IN-1:0]  core_in;
  logic [N_OUT-1:0] core_out = '0;
  logic [N_OUT-1:0] pin_out;
  logic             core_oe = 1'b0;
  logic             pin_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #10 tck = ~tck;

  bscan_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) i_bscan_chain (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(posedge tck); #2; mode = m; #1;
  endtask

  task automatic strobe_cap();
    @(posedge tck); #2; cap_dr = 1'b1;
    @(posedge tck); #2; cap_dr = 1'b0; #1;
  endtask

  task automatic strobe_upd();
    @(posedge tck); #2; upd_dr = 1'b1;
    @(posedge tck); #2; upd_dr = 1'b0; #1;
  endtask

  // driver: pushes expected serial bits, monitor compares at mid-cycle
  task automatic shift_vec(input logic [L-1:0] din, input logic [L-1:0] exp,
                           input string r, input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge tck); #2;
      shift_dr = 1'b1; tdi = din[k];
      exp_q.push_back(exp[k]); tag_q.push_back(r);
    end
    @(posedge tck); #2; shift_dr = 1'b0; #1;
  endtask

  always @(negedge tck) begin
    if (shift_dr && exp_q.size() > 0) begin
      logic e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      chk(t, scan_out, e);
    end
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge tck);
    #2; trst_n = 1'b1; #1;
    // R1: reset state
    chk("R1 scan_out", scan_out, 0);
    set_mode(3'd2);
    chk("R1 extest pin_out", pin_out, 0);
    chk("R1 extest pin_oe", pin_oe, 0);
    set_mode(3'd1);
    shift_vec('0, '0, "R1 chain zero", L);

    // R2: functional pass-through
    set_mode(3'd0);
    pin_in = 4'h5; core_out = 4'hA; core_oe = 1'b1; #1;
    chk("R2 pin_out", pin_out, 4'hA);
    chk("R2 core_in", core_in, 4'h5);
    chk("R2 pin_oe", pin_oe, 1);

    // R3/R4/R5: SAMPLE capture, shift out, preload
    set_mode(3'd1);
    pin_in = 4'hA; core_out = 4'h6; core_oe = 1'b1;
    strobe_cap();
    chk("R3 sample pin_out", pin_out, 4'h6);
    chk("R3 sample core_in", core_in, 4'hA);
    shift_vec(9'b1_0011_0101, 9'b1_0110_1010, "R4 sample shift", L);
    strobe_upd();
    chk("R2 sample pin_out after preload", pin_out, 4'h6);

    // R6: EXTEST drives pins from preloaded latches
    set_mode(3'd2);
    chk("R6 pin_out", pin_out, 4'h3);
    chk("R6 pin_oe", pin_oe, 1);
    chk("R6 core_in", core_in, 4'hA);
    pin_in = 4'hC; core_out = 4'h9; core_oe = 1'b0;
    strobe_cap();
    shift_vec(9'b0_1100_1010, 9'b0_1001_1100, "R6 extest shift", L);
    chk("R5 pins hold during shift", pin_out, 4'h3);
    chk("R5 oe hold during shift", pin_oe, 1);
    strobe_upd();
    chk("R5 pin_out after update", pin_out, 4'hC);
    chk("R6 pin_oe from latch", pin_oe, 0);

    // R7: INTEST
    set_mode(3'd3);
    chk("R7 core_in from latch", core_in, 4'hA);
    chk("R7 pin_out from latch", pin_out, 4'hC);
    pin_in = 4'h3; core_out = 4'h7; core_oe = 1'b1;
    strobe_cap();
    shift_vec(9'b1_0110_0001, 9'b1_0111_0011, "R7 intest response", L);
    strobe_upd();
    chk("R7 core_in new pattern", core_in, 4'h1);

    // R8: CLAMP
    set_mode(3'd4);
    chk("R8 pin_out clamped", pin_out, 4'h6);
    chk("R8 pin_oe clamped", pin_oe, 1);
    chk("R8 core_in functional", core_in, 4'h3);
    strobe_cap();
    shift_vec(9'b0_0000_1101, 9'b0_0000_1010, "R8 bypass path", 4);
    core_out = 4'hE;
    strobe_upd();
    chk("R10 clamp update ignored", pin_out, 4'h6);

    // R9: HIGHZ
    set_mode(3'd5);
    core_oe = 1'b1; #1;
    chk("R9 pin_oe off", pin_oe, 0);
    chk("R9 pin_out", pin_out, 4'hE);
    strobe_cap();
    shift_vec(9'b0_0000_0110, 9'b0_0000_1100, "R9 bypass path", 4);
    strobe_upd();

    // R10: chain untouched by bypass modes
    set_mode(3'd1);
    shift_vec('0, 9'b1_0110_0001, "R10 chain preserved", L);
    set_mode(3'd2);
    chk("R10 latches preserved", pin_out, 4'h6);

    // R2: unused code behaves functionally
    set_mode(3'd7);
    pin_in = 4'h9; core_out = 4'h2; core_oe = 1'b0; #1;
    chk("R2 code7 pin_out", pin_out, 4'h2);
    chk("R2 code7 core_in", core_in, 4'h9);
    chk("R2 code7 pin_oe", pin_oe, 0);

    repeat (2) @(posedge tck);
    chk("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule